// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor core that retires one instruction per clock cycle. It covers a reduced integer instruction set: register-register add, subtract, bitwise and, bitwise or and set-on-less-than; add-immediate; word load and store; branch-if-equal; and an unconditional jump. The core contains the program counter, a register file with combinational reads, a sign extender, an ALU, the control decoders and the next-address selection.

The core has two memory ports. The instruction port drives a byte address and takes back an instruction word in the same cycle. The data port drives an address, write data and a write strobe, and takes back a read word in the same cycle. The memories themselves sit outside the core. Register writes, data stores and the program-counter update all happen on the rising clock edge. A synchronous reset returns the program counter to its reset address. An unrecognised instruction passes through as a no-op.

Top module: `sc_core`

## Requirements
- R1: While reset is high, the instruction address becomes 0 at the next rising edge. When an instruction is neither a branch nor a jump, the address then advances by 4 on each edge.
- R2: An R-type instruction (opcode 000000) whose funct is add 100000, sub 100010, and 100100 or or 100101 writes A+B, A−B, A&B or A|B into the register named by bits 15:11. A is register bits 25:21 and B is register bits 20:16. The ALU result appears on the data address port during that cycle.
- R3: Funct 101010 writes 1 when A is below B as an unsigned number, and writes 0 otherwise.
- R4: addi (001000) and lw (100011) add the base register (bits 25:21) to bits 15:0, sign-extended from bit 15. addi writes that sum into the register in bits 20:16. lw writes the data read port value at that address into the same register.
- R5: sw (101011) raises the data write strobe. Its address is the base plus the sign-extended offset, and its write data is the register in bits 20:16. No other opcode raises the strobe.
- R6: beq (000100) compares its two registers by subtraction, and the difference appears on the data address port. If the two are equal, the next address is PC+4 plus the sign-extended offset shifted left by 2. Otherwise the next address is PC+4.
- R7: j (000010) loads the next address from the top 4 bits of PC+4, then bits 25:0 of the instruction, then 2'b00.
- R8: Register 0 always reads as zero, even after an instruction writes to it.
- R9: An unrecognised opcode, or an R-type with an unrecognised funct, writes no register and no memory. The address then advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the current instruction (the program counter) |
| imem_word | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | ALU result, used as the data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken at the rising edge |
| dmem_rdata | input | 32 | Data word at dmem_addr |

## Verification
The bound checker watches control flow on every cycle. It checks that the address stays word-aligned, that a non-control instruction advances by exactly 4, that a jump lands on its concatenated target, and that a branch lands on one of its two legal successors. It also checks that only a store raises the strobe, and that reset forces the start address. Some behaviour depends on register contents, and only the bench program can show it. That covers the ALU results, the unsigned character of set-on-less-than, and the round trip from a store to a later load. It also covers register 0 staying zero after a write, and unknown encodings leaving their destination unchanged.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
   localparam logic [5:0] OP_RTYPE = 6'b000000;
   localparam logic [5:0] OP_LOADW = 6'b100011;
   localparam logic [5:0] OP_STORW = 6'b101011;
   localparam logic [5:0] OP_BREQ  = 6'b000100;
   localparam logic [5:0] OP_ADDI  = 6'b001000;
   localparam logic [5:0] OP_JUMP  = 6'b000010;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   // bit 2: invert B with carry-in; bits 1:0: operation select
   typedef enum logic [2:0] {
      ALU_AND  = 3'b000,
      ALU_OR   = 3'b001,
      ALU_ADD  = 3'b010,
      ALU_ANDN = 3'b100,
      ALU_ORN  = 3'b101,
      ALU_SUB  = 3'b110,
      ALU_LTU  = 3'b111
   } alu_op_e;

   typedef enum logic [1:0] {
      AC_ADD   = 2'b00,
      AC_SUB   = 2'b01,
      AC_FUNCT = 2'b10
   } alu_class_e;

   typedef struct packed {
      logic       reg_we;
      logic       dst_rd;
      logic       b_imm;
      logic       branch;
      logic       mem_we;
      logic       load;
      logic       jump;
      alu_class_e aclass;
   } ctrl_t;
endpackage

// File: rtl/sc_core_regs.sv
module sc_core_regs #(
   parameter int DW    = 32,
   parameter int DEPTH = 32
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] wa,
   input  logic [DW-1:0]            wd,
   input  logic [$clog2(DEPTH)-1:0] ra1,
   input  logic [$clog2(DEPTH)-1:0] ra2,
   output logic [DW-1:0]            rd1,
   output logic [DW-1:0]            rd2
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("sc_core_regs: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [DW-1:0] rows [DEPTH];

   always_ff @(posedge clk) begin
      if (we && wa != '0) rows[wa] <= wd;
   end

   assign rd1 = (ra1 == '0) ? '0 : rows[ra1];
   assign rd2 = (ra2 == '0) ? '0 : rows[ra2];
endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
   import sc_core_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  alu_op_e       op,
   output logic [DW-1:0] y,
   output logic          zero
);
   logic [DW-1:0] b_sel;
   logic [DW:0]   sum;
   logic          below;

   assign b_sel = op[2] ? ~b : b;
   assign sum   = {1'b0, a} + {1'b0, b_sel} + {{DW{1'b0}}, op[2]};
   // unsigned below: no carry out and nonzero difference
   assign below = ~sum[DW] & (sum[DW-1:0] != '0);

   always_comb begin
      unique case (op[1:0])
         2'b00:   y = a & b_sel;
         2'b01:   y = a | b_sel;
         2'b10:   y = sum[DW-1:0];
         default: y = {{(DW-1){1'b0}}, below};
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/sc_core_decode.sv
module sc_core_decode
   import sc_core_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctl,
   output alu_op_e    alu_op
);
   ctrl_t raw;
   logic  fn_ok;

   always_comb begin
      raw = '0;
      unique case (opcode)
         OP_RTYPE: begin raw.reg_we = 1'b1; raw.dst_rd = 1'b1; raw.aclass = AC_FUNCT; end
         OP_LOADW: begin raw.reg_we = 1'b1; raw.b_imm = 1'b1; raw.load = 1'b1; end
         OP_STORW: begin raw.b_imm = 1'b1; raw.mem_we = 1'b1; end
         OP_BREQ:  begin raw.branch = 1'b1; raw.aclass = AC_SUB; end
         OP_ADDI:  begin raw.reg_we = 1'b1; raw.b_imm = 1'b1; end
         OP_JUMP:  raw.jump = 1'b1;
         default:  raw = '0;
      endcase
   end

   always_comb begin
      fn_ok  = 1'b1;
      alu_op = ALU_ADD;
      unique case (raw.aclass)
         AC_ADD: alu_op = ALU_ADD;
         AC_SUB: alu_op = ALU_SUB;
         default: begin
            unique case (funct)
               FN_ADD:  alu_op = ALU_ADD;
               FN_SUB:  alu_op = ALU_SUB;
               FN_AND:  alu_op = ALU_AND;
               FN_OR:   alu_op = ALU_OR;
               FN_SLT:  alu_op = ALU_LTU;
               default: fn_ok  = 1'b0;
            endcase
         end
      endcase
   end

   always_comb begin
      ctl        = raw;
      ctl.reg_we = raw.reg_we & fn_ok;
   end
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_core_pkg::*;
#(
   parameter int          REG_COUNT = 32,
   parameter logic [31:0] RESET_PC  = 32'h0
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] imem_addr,
   input  logic [31:0] imem_word,
   output logic [31:0] dmem_addr,
   output logic [31:0] dmem_wdata,
   output logic        dmem_we,
   input  logic [31:0] dmem_rdata
);
   localparam int DW = 32;
   localparam int AW = $clog2(REG_COUNT);

   generate
      if (AW > 5 || AW < 1) begin : g_bad_regs
         $error("sc_core: REG_COUNT must be between 2 and 32");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_pc
         $error("sc_core: RESET_PC must be word aligned");
      end
   endgenerate

   logic [DW-1:0] pc, pc_p4, pc_br, pc_jt, pc_nx;
   logic [DW-1:0] imm_x, rs_v, rt_v, b_v, alu_y, wb_v;
   logic [AW-1:0] wa;
   logic          alu_z;
   ctrl_t         ctl;
   alu_op_e       aop;

   sc_core_decode u_dec (
      .opcode (imem_word[31:26]),
      .funct  (imem_word[5:0]),
      .ctl    (ctl),
      .alu_op (aop)
   );

   assign wa = ctl.dst_rd ? imem_word[11 +: AW] : imem_word[16 +: AW];

   sc_core_regs #(.DW(DW), .DEPTH(REG_COUNT)) u_rf (
      .clk (clk),
      .we  (ctl.reg_we),
      .wa  (wa),
      .wd  (wb_v),
      .ra1 (imem_word[21 +: AW]),
      .ra2 (imem_word[16 +: AW]),
      .rd1 (rs_v),
      .rd2 (rt_v)
   );

   assign imm_x = {{(DW-16){imem_word[15]}}, imem_word[15:0]};
   assign b_v   = ctl.b_imm ? imm_x : rt_v;

   sc_core_alu #(.DW(DW)) u_alu (
      .a    (rs_v),
      .b    (b_v),
      .op   (aop),
      .y    (alu_y),
      .zero (alu_z)
   );

   assign wb_v  = ctl.load ? dmem_rdata : alu_y;

   assign pc_p4 = pc + 32'd4;
   assign pc_br = pc_p4 + {imm_x[DW-3:0], 2'b00};
   assign pc_jt = {pc_p4[31:28], imem_word[25:0], 2'b00};

   always_comb begin
      if (ctl.jump)                pc_nx = pc_jt;
      else if (ctl.branch && alu_z) pc_nx = pc_br;
      else                         pc_nx = pc_p4;
   end

   always_ff @(posedge clk) begin
      if (rst) pc <= RESET_PC;
      else     pc <= pc_nx;
   end

   assign imem_addr  = pc;
   assign dmem_addr  = alu_y;
   assign dmem_wdata = rt_v;
   assign dmem_we    = ctl.mem_we;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input logic        clk,
   input logic        rst,
   input logic [31:0] pc,
   input logic [31:0] ins,
   input logic        we
);
   logic [5:0]  op;
   logic [31:0] nxt4, br_t, jp_t;
   logic        known;

   assign op    = ins[31:26];
   assign nxt4  = pc + 32'd4;
   assign br_t  = nxt4 + {{14{ins[15]}}, ins[15:0], 2'b00};
   assign jp_t  = {nxt4[31:28], ins[25:0], 2'b00};
   assign known = (op == 6'b000000) || (op == 6'b100011) || (op == 6'b101011) ||
                  (op == 6'b000100) || (op == 6'b001000) || (op == 6'b000010);

   // R1
   reset_pc_chk: assert property (@(posedge clk) rst |=> pc == RESET_PC);

   // R1
   aligned_pc_chk: assert property (@(posedge clk) disable iff (rst)
      pc[1:0] == 2'b00);

   // R1
   seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
      (op != 6'b000100 && op != 6'b000010) |=> pc == $past(nxt4));

   // R5
   store_only_we_chk: assert property (@(posedge clk) disable iff (rst)
      we |-> op == 6'b101011);

   // R6
   branch_succ_chk: assert property (@(posedge clk) disable iff (rst)
      op == 6'b000100 |=> (pc == $past(nxt4) || pc == $past(br_t)));

   // R7
   jump_target_chk: assert property (@(posedge clk) disable iff (rst)
      op == 6'b000010 |=> pc == $past(jp_t));

   // R9
   unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !known |-> !we);
endmodule

bind sc_core sc_core_chk #(.RESET_PC(RESET_PC)) u_chk (
   .clk (clk),
   .rst (rst),
   .pc  (imem_addr),
   .ins (imem_word),
   .we  (dmem_we)
);

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;
   typedef struct packed {
      logic [31:0] pc;
      logic [31:0] ins;
      logic [31:0] alu;
      logic [31:0] wd;
      logic        we;
      logic        ck;
      logic [3:0]  rq;
   } vec_t;

   function automatic logic [31:0] enc_r(int f, int s, int t, int d);
      return {6'd0, s[4:0], t[4:0], d[4:0], 5'd0, f[5:0]};
   endfunction
   function automatic logic [31:0] enc_i(int o, int s, int t, int imm);
      return {o[5:0], s[4:0], t[4:0], imm[15:0]};
   endfunction
   function automatic logic [31:0] enc_j(int a);
      return {6'b000010, a[25:0]};
   endfunction
   function automatic vec_t mk(int pc, logic [31:0] ins, logic [31:0] alu,
                               logic [31:0] wd, logic we, logic ck, int rq);
      return '{pc: pc[31:0], ins: ins, alu: alu, wd: wd, we: we, ck: ck, rq: rq[3:0]};
   endfunction

   localparam int NV = 23;
   localparam vec_t TBL [NV] = '{
      mk(  0, enc_i(8, 0, 1, 5),       32'd5,        0, 0, 1, 4), // R4 addi r1=5
      mk(  4, enc_i(8, 0, 2, -3),      32'hFFFFFFFD, 0, 0, 1, 4), // R4 addi r2=-3
      mk(  8, enc_r(32, 1, 2, 3),      32'd2,        0, 0, 1, 2), // R2 add
      mk( 12, enc_r(34, 1, 2, 4),      32'd8,        0, 0, 1, 2), // R2 sub
      mk( 16, enc_r(36, 1, 4, 5),      32'd0,        0, 0, 1, 2), // R2 and
      mk( 20, enc_r(37, 1, 4, 6),      32'd13,       0, 0, 1, 2), // R2 or
      mk( 24, enc_r(42, 1, 2, 7),      32'd1,        0, 0, 1, 3), // R3 5 < big
      mk( 28, enc_r(42, 2, 1, 8),      32'd0,        0, 0, 1, 3), // R3 big !< 5
      mk( 32, enc_i(43, 0, 6, 8),      32'd8,        13, 1, 1, 5), // R5 sw
      mk( 36, enc_i(35, 0, 9, 8),      32'd8,        0, 0, 1, 4), // R4 lw r9
      mk( 40, enc_i(8, 0, 0, 7),       32'd7,        0, 0, 1, 8), // R8 write r0
      mk( 44, enc_r(32, 0, 9, 10),     32'd13,       0, 0, 1, 8), // R8 r0 still 0
      mk( 48, enc_i(4, 9, 6, 2),       32'd0,        0, 0, 1, 6), // R6 taken
      mk( 60, enc_i(4, 1, 2, 5),       32'd8,        0, 0, 1, 6), // R6 not taken
      mk( 64, enc_j(20),               32'd0,        0, 0, 0, 7), // R7 jump to 80
      mk( 80, enc_i(63, 0, 1, 0),      32'd0,        0, 0, 0, 7), // R7 target reached
      mk( 84, enc_r(0, 6, 6, 1),       32'd0,        0, 0, 0, 9), // R9 bad opcode skipped
      mk( 88, enc_r(32, 1, 0, 11),     32'd5,        0, 0, 1, 9), // R9 r1 unchanged
      mk( 92, enc_i(43, 6, 1, -5),     32'd8,        5, 1, 1, 5), // R5 negative offset
      mk( 96, enc_i(35, 0, 12, 8),     32'd8,        0, 0, 1, 4), // R4 load back
      mk(100, enc_r(34, 12, 11, 13),   32'd0,        0, 0, 1, 2), // R2 sub to zero
      mk(104, enc_i(4, 0, 0, -1),      32'd0,        0, 0, 1, 6), // R6 self loop
      mk(104, enc_i(4, 0, 0, -1),      32'd0,        0, 0, 1, 6)  // R6 loop holds
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_word, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;
   logic [31:0] imem [64];
   logic [31:0] dmem [64];
   int          total = 0;
   int          bad   = 0;
   bit          done  = 1'b0;

   always #2 clk = ~clk;

   assign imem_word  = imem[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_addr[7:2]];

   always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

   sc_core u0 (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_word  (imem_word),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin imem[i] = '0; dmem[i] = '0; end
      for (int i = 0; i < NV; i++) imem[TBL[i].pc[7:2]] = TBL[i].ins;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset pc", imem_addr, 32'd0);
      rst = 1'b0;
      for (int i = 0; i < NV; i++) begin
         check($sformatf("R%0d pc step %0d", TBL[i].rq, i), imem_addr, TBL[i].pc);
         check($sformatf("R%0d we step %0d", TBL[i].rq, i), {31'd0, dmem_we}, {31'd0, TBL[i].we});
         if (TBL[i].ck)
            check($sformatf("R%0d alu step %0d", TBL[i].rq, i), dmem_addr, TBL[i].alu);
         if (TBL[i].we)
            check($sformatf("R%0d wdata step %0d", TBL[i].rq, i), dmem_wdata, TBL[i].wd);
         @(posedge clk);
         @(negedge clk);
      end
      // R1: reset mid-run returns to 0, then sequential restart
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R1 reset mid-run", imem_addr, 32'd0);
      rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R1 restart +4", imem_addr, 32'd4);
      check("R4 restart addi", dmem_addr, 32'hFFFFFFFD);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule